// File: doc/BRIEF.md
# Timer Channel Event Status Register

This block holds the sticky status of one timer channel. A capture or compare-match pulse raises the event flag. A further event that arrives while that flag is still pending raises an overrun flag. A counter-overflow pulse raises an overflow flag. Software clears each flag by writing a 1 to its bit. When the channel runs in DMA mode, an acknowledge pulse from the DMA engine can clear the event flag in place of software.

The same word also returns two read-only bits: the conditioned input pin level and the present output pin level. A request output follows the event flag, and the interrupt or DMA logic watches it. The bus port is a simple select/write-enable/address interface. A read returns its data one cycle after the request.

Top module: `chan_evt_stat`

## Requirements
- R1: After a synchronous reset, the event flag, overrun flag and overflow flag are 0, `flag_req` is 0 and `rdata` is 0.
- R2: A cycle with `cap_evt` or `match_evt` high sets the event flag, and `flag_req` is 1 in the following cycle.
- R3: A write to offset 0x10 with `wdata[0]` = 1 clears the event flag. Writing 0 to any flag bit changes nothing.
- R4: An event-setting cycle that finds the event flag already 1 sets the overrun flag.
- R5: The overrun flag clears whenever the event flag is cleared, by any means. It also clears on a write of 1 to `wdata[31]` at offset 0x10.
- R6: A cycle with `ovf_evt` high sets the overflow flag. Only a write of 1 to `wdata[15]` at offset 0x10 clears it.
- R7: With `dma_en` = 1, a `dma_ack` pulse clears the event flag. With `dma_en` = 0, `dma_ack` has no effect.
- R8: When an event and a clear (write or DMA acknowledge) fall in the same cycle, the event flag ends at 1. Overrun is set only if the flag was already 1 before that cycle.
- R9: A read (`sel`=1, `wr_en`=0, `addr`=0x10) returns the word on `rdata` in the next cycle, with overrun on bit 31, overflow on bit 15, input level on bit 2, output level on bit 1, event flag on bit 0, and all other bits 0. Without such a read, `rdata` is 0. A read changes no flag.
- R10: Bits 2 and 1 show `pin_in` and `pin_out` as they stood in the read cycle. Writes to those bits are ignored.
- R11: `flag_req` always equals the event flag.
- R12: Writes to any offset other than 0x10 change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Bus access strobe |
| wr_en | input | 1 | 1 = write, 0 = read |
| addr | input | 8 | Byte offset within the channel window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| cap_evt | input | 1 | Input-capture pulse |
| match_evt | input | 1 | Comparator match pulse |
| ovf_evt | input | 1 | Counter overflow pulse |
| dma_en | input | 1 | Channel DMA mode enable |
| dma_ack | input | 1 | DMA acknowledge pulse |
| pin_in | input | 1 | Filtered, synchronized input level |
| pin_out | input | 1 | Output pin level |
| flag_req | output | 1 | Interrupt/DMA request, equals event flag |

## Verification
A wrong event-flag state shows on `flag_req` in the cycle after the offending edge. A wrong overrun or overflow state is visible only through a read, one cycle after the read request. The bench therefore reads the word after every stimulus cycle, so a corrupted flag is caught at most two cycles after it goes wrong. The sweep visits every valid combination of the two coupled flags against every mix of set and clear sources, so a wrong priority between set and clear shows as a wrong bit in that read.

// File: rtl/chan_evt_pkg.sv
package chan_evt_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 8;
    localparam logic [ADDR_W-1:0] STAT_OFS = 8'h10;

    // MSB-first field positions; converted to vector indices below
    localparam int POS_OVR  = 0;
    localparam int POS_OVF  = 16;
    localparam int POS_PIN  = 29;
    localparam int POS_POUT = 30;
    localparam int POS_FLAG = 31;

    function automatic int vidx(input int msb_pos);
        return DATA_W - 1 - msb_pos;
    endfunction

    localparam int IX_OVR  = vidx(POS_OVR);
    localparam int IX_OVF  = vidx(POS_OVF);
    localparam int IX_PIN  = vidx(POS_PIN);
    localparam int IX_POUT = vidx(POS_POUT);
    localparam int IX_FLAG = vidx(POS_FLAG);

    typedef struct packed {
        logic ovr;
        logic ovf;
        logic flag;
    } stat_t;

    typedef struct packed {
        logic set_evt;
        logic clr_flag;
        logic clr_ovr;
        logic ovf_evt;
        logic clr_ovf;
    } ctl_t;

    function automatic logic [DATA_W-1:0] pack_word(input stat_t s,
                                                    input logic lvl_in,
                                                    input logic lvl_out);
        logic [DATA_W-1:0] w;
        w = '0;
        w[IX_OVR]  = s.ovr;
        w[IX_OVF]  = s.ovf;
        w[IX_PIN]  = lvl_in;
        w[IX_POUT] = lvl_out;
        w[IX_FLAG] = s.flag;
        return w;
    endfunction
endpackage

// File: rtl/evt_flag_core.sv
module evt_flag_core (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic clr_flag,
    input  logic clr_ovr,
    output logic flag_q,
    output logic ovr_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            if (set_evt)       flag_q <= 1'b1;
            else if (clr_flag) flag_q <= 1'b0;

            if (set_evt && flag_q) ovr_q <= 1'b1;
            else if (set_evt)      ovr_q <= ovr_q;
            else if (clr_flag)     ovr_q <= 1'b0;
            else if (clr_ovr)      ovr_q <= 1'b0;
        end
    end

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        set_evt |=> flag_q);                                   // R2
    AST_OVR_ON_REPEAT: assert property (@(posedge clk) disable iff (rst)
        (set_evt && flag_q) |=> ovr_q);                        // R4
    AST_OVR_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        ovr_q |-> flag_q);                                     // R5
    AST_CLR_DROPS_BOTH: assert property (@(posedge clk) disable iff (rst)
        (clr_flag && !set_evt) |=> (!flag_q && !ovr_q));       // R5
    AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (rst)
        (set_evt && clr_flag && !flag_q) |=> (flag_q && !ovr_q)); // R8
endmodule

// File: rtl/ovf_flag_core.sv
module ovf_flag_core (
    input  logic clk,
    input  logic rst,
    input  logic ovf_evt,
    input  logic clr_ovf,
    output logic ovf_q
);
    always_ff @(posedge clk) begin
        if (rst)          ovf_q <= 1'b0;
        else if (ovf_evt) ovf_q <= 1'b1;
        else if (clr_ovf) ovf_q <= 1'b0;
    end

    AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
        ovf_evt |=> ovf_q);                                    // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !clr_ovf) |=> ovf_q);                        // R6
endmodule

// File: rtl/stat_rd_port.sv
module stat_rd_port
    import chan_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_hit,
    input  stat_t             st,
    input  logic              lvl_in,
    input  logic              lvl_out,
    output logic [DATA_W-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst)         rdata <= '0;
        else if (rd_hit) rdata <= pack_word(st, lvl_in, lvl_out);
        else             rdata <= '0;
    end
endmodule

// File: rtl/chan_evt_stat.sv
module chan_evt_stat
    import chan_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              cap_evt,
    input  logic              match_evt,
    input  logic              ovf_evt,
    input  logic              dma_en,
    input  logic              dma_ack,
    input  logic              pin_in,
    input  logic              pin_out,
    output logic              flag_req
);
    logic  hit, wr_hit, rd_hit;
    ctl_t  ctl;
    stat_t st;
    logic  unused_wbits;

    assign hit    = sel && (addr == STAT_OFS);
    assign wr_hit = hit && wr_en;
    assign rd_hit = hit && !wr_en;
    assign unused_wbits = ^wdata;

    always_comb begin
        ctl.set_evt  = cap_evt | match_evt;
        ctl.clr_flag = (wr_hit && wdata[IX_FLAG]) || (dma_en && dma_ack);
        ctl.clr_ovr  = wr_hit && wdata[IX_OVR];
        ctl.ovf_evt  = ovf_evt;
        ctl.clr_ovf  = wr_hit && wdata[IX_OVF];
    end

    evt_flag_core u_evt (
        .clk(clk), .rst(rst),
        .set_evt(ctl.set_evt), .clr_flag(ctl.clr_flag), .clr_ovr(ctl.clr_ovr),
        .flag_q(st.flag), .ovr_q(st.ovr)
    );

    ovf_flag_core u_ovf (
        .clk(clk), .rst(rst),
        .ovf_evt(ctl.ovf_evt), .clr_ovf(ctl.clr_ovf), .ovf_q(st.ovf)
    );

    stat_rd_port u_rd (
        .clk(clk), .rst(rst), .rd_hit(rd_hit), .st(st),
        .lvl_in(pin_in), .lvl_out(pin_out), .rdata(rdata)
    );

    assign flag_req = st.flag;

    AST_DMA_GATED: assert property (@(posedge clk) disable iff (rst)
        (!dma_en && dma_ack && !wr_hit && flag_req) |=> flag_req);  // R7
    AST_FOREIGN_WRITE: assert property (@(posedge clk) disable iff (rst)
        (sel && wr_en && !hit && !cap_evt && !match_evt && !ovf_evt && !dma_ack)
        |=> $stable(st));                                      // R12
    AST_READ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (rd_hit && !cap_evt && !match_evt && !ovf_evt && !dma_ack)
        |=> $stable(st));                                      // R9
endmodule

// File: tb/chan_evt_stat_test.sv
`timescale 1ns/1ps
module chan_evt_stat_test;
    logic        clk = 0, rst = 1;
    logic        sel = 0, wr_en = 0;
    logic [7:0]  addr = 0;
    logic [31:0] wdata = 0, rdata;
    logic cap_evt = 0, match_evt = 0, ovf_evt = 0, dma_en = 0, dma_ack = 0;
    logic pin_in = 0, pin_out = 0, flag_req;
    int errors = 0, checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    chan_evt_stat uut (
        .clk(clk), .rst(rst), .sel(sel), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .cap_evt(cap_evt), .match_evt(match_evt),
        .ovf_evt(ovf_evt), .dma_en(dma_en), .dma_ack(dma_ack),
        .pin_in(pin_in), .pin_out(pin_out), .flag_req(flag_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word(input bit o, input bit v, input bit f,
                                         input bit pi, input bit po);
        return {o, 15'd0, v, 12'd0, pi, po, f};
    endfunction

    task automatic do_reset();
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
    endtask

    // one stimulus cycle, entered and left at a falling edge
    task automatic drive(input bit c, input bit m, input bit v, input bit w,
                         input logic [7:0] a, input logic [31:0] d,
                         input bit de, input bit da);
        cap_evt = c; match_evt = m; ovf_evt = v;
        sel = w; wr_en = w; addr = a; wdata = d; dma_en = de; dma_ack = da;
        @(negedge clk);
        cap_evt = 0; match_evt = 0; ovf_evt = 0;
        sel = 0; wr_en = 0; addr = 0; wdata = 0; dma_en = 0; dma_ack = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] r);
        sel = 1; wr_en = 0; addr = a;
        @(negedge clk);
        sel = 0; addr = 0;
        r = rdata;
    endtask

    logic [31:0] r;

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        chk("R1 rdata", rdata, 0);
        chk("R1 flag_req", {31'd0, flag_req}, 0);
        rd(8'h10, r);
        chk("R1 word", r, 0);

        // event/overrun sweep: states (f,o) in {00,10,11} x all 64 stimulus mixes
        for (int s = 0; s < 3; s++) begin
            for (int k = 0; k < 64; k++) begin
                bit f, o, c, m, wf, wo, de, da, set, clr, ef, eo;
                f = (s != 0); o = (s == 2);
                {c, m, wf, wo, de, da} = k[5:0];
                do_reset();
                if (f) drive(1, 0, 0, 0, 0, 0, 0, 0);
                if (o) drive(0, 1, 0, 0, 0, 0, 0, 0);
                drive(c, m, 0, wf | wo, 8'h10, {wo, 30'd0, wf}, de, da);
                set = c | m;
                clr = wf | (de & da);
                ef  = set ? 1'b1 : (clr ? 1'b0 : f);
                eo  = (set & f) ? 1'b1 : (set ? o : ((clr | wo) ? 1'b0 : o));
                chk("R11 flag_req tracks flag (R2 R3 R7 R8)", {31'd0, flag_req}, {31'd0, ef});
                rd(8'h10, r);
                chk("R4 R5 R8 word after mix", r, word(eo, 0, ef, 0, 0));
            end
        end

        // overflow sweep: initial state x event x clear write
        for (int k = 0; k < 8; k++) begin
            bit v0, ev, wv, ex;
            {v0, ev, wv} = k[2:0];
            do_reset();
            if (v0) drive(0, 0, 1, 0, 0, 0, 0, 0);
            drive(0, 0, ev, wv, 8'h10, 32'h0000_8000, 0, 0);
            ex = ev ? 1'b1 : (wv ? 1'b0 : v0);
            rd(8'h10, r);
            chk("R6 overflow", r, word(0, ex, 0, 0, 0));
        end

        // zero writes and foreign offsets leave all flags set
        do_reset();
        drive(1, 0, 1, 0, 0, 0, 0, 0);
        drive(0, 1, 0, 0, 0, 0, 0, 0);
        drive(0, 0, 0, 1, 8'h10, 32'h0, 0, 0);
        rd(8'h10, r);
        chk("R3 zero write ignored", r, word(1, 1, 1, 0, 0));
        for (int a = 0; a < 32; a += 4) begin
            if (a != 16) drive(0, 0, 0, 1, a[7:0], 32'hFFFF_FFFF, 0, 0);
        end
        drive(0, 0, 0, 1, 8'h90, 32'hFFFF_FFFF, 0, 0);
        rd(8'h10, r);
        chk("R12 foreign writes ignored", r, word(1, 1, 1, 0, 0));
        rd(8'h14, r);
        chk("R9 other offset reads 0", r, 0);
        rd(8'h10, r);
        chk("R9 repeated read unchanged", r, word(1, 1, 1, 0, 0));
        @(negedge clk);
        chk("R9 rdata idle 0", rdata, 0);

        // pin levels, with writes of ones to their bits
        for (int p = 0; p < 4; p++) begin
            do_reset();
            pin_in = p[1]; pin_out = p[0];
            drive(0, 0, 0, 1, 8'h10, 32'h0000_0006, 0, 0);
            rd(8'h10, r);
            chk("R10 pin levels", r, word(0, 0, 0, p[1], p[0]));
        end
        pin_in = 0; pin_out = 0;

        // R1: reset clears everything that was set
        drive(1, 0, 1, 0, 0, 0, 0, 0);
        drive(1, 0, 0, 0, 0, 0, 0, 0);
        do_reset();
        chk("R1 flag_req after reset", {31'd0, flag_req}, 0);
        rd(8'h10, r);
        chk("R1 word after reset", r, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule